// File: doc/BRIEF.md
# Memory Bit-Manipulation Read-Modify-Write Unit

This unit changes or inspects a single bit of one byte in memory. A command carries an operation code, a 32-bit byte address and a 3-bit bit index. The unit reads the byte through a synchronous memory port, works out the new value, and writes it back to the same address in the next cycle. Five operations are supported: set, clear and toggle of the indexed bit; a test that writes nothing back; and an atomic load-and-set. Load-and-set returns the old byte and stores 0x01, and it keeps a lock output high across its read and its write.

Commands use a valid/ready handshake. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the unit is idle. A `cmd_valid` raised while the unit is busy is not stored and has no effect. It is not held for later either, so the sender must keep it raised until it sees ready. The result side has no back-pressure. `res_valid` is a one-cycle strobe, and `res_data` stays valid until the next result replaces it.

Top module: `bitrmw_unit`

## Requirements
- R1: Operation code 0 (set) writes back the old byte OR the one-hot mask of the bit index. The result is the written byte, zero-extended.
- R2: Operation code 1 (clear) writes back the old byte AND the inverted mask. The result is the written byte, zero-extended.
- R3: Operation code 2 (toggle) writes back the old byte XOR the mask. The result is the written byte, zero-extended.
- R4: Operation code 3 (test) issues no write. The result is the old byte AND the mask, zero-extended to 32 bits.
- R5: Operation code 4 (load-and-set) returns the old byte zero-extended and writes 0x01 to the same address.
- R6: Timing after a command is accepted on edge P:
  - The read is presented in the cycle after P.
  - Any write follows in the next cycle, at the same address.
  - `res_valid` is high for exactly one cycle after that.
  - The result therefore appears two cycles after the cycle in which acceptance becomes visible.
- R7: `cmd_ready` is low from acceptance until the unit is idle again. A `cmd_valid` raised while busy changes no memory and produces no result.
- R8: `mem_lock` is high in exactly the read cycle and the write cycle of a load-and-set, and low at all other times.
- R9: Operation codes 5 to 7 read the byte, write nothing and return 0.
- R10: While reset is asserted the unit holds these values:
  - `cmd_ready` is 1.
  - `res_valid`, `mem_rd_en`, `mem_wr_en` and `mem_lock` are 0.
  - `res_data` is 0.
- R11: The bit index selects bit `cmd_bit` of the byte, where index 0 is the least significant bit. Indices 0 and 7 both address real bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 32 | Byte address |
| cmd_bit | input | 3 | Bit index within the byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 32 | Result for the destination register |
| mem_addr | output | 32 | Memory byte address |
| mem_rd_en | output | 1 | Read request; data is returned one cycle later |
| mem_rdata | input | 8 | Read data |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_lock | output | 1 | Atomic sequence in progress |

## Verification
The assertions take three things about the environment for granted:
- The memory returns the addressed byte exactly one cycle after `mem_rd_en`.
- No other master writes that byte between the read and the write.
- The command fields matter only on the accepting edge.

The bench keeps to these assumptions with a registered byte memory model of its own that nothing else writes. Its driver raises `cmd_valid` only when `cmd_ready` is high, with one exception: a deliberate poke during a busy sequence. That poke is withdrawn before the unit returns to idle.

// File: rtl/bitrmw_pkg.sv
package bitrmw_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_SET   = 3'd0;
  localparam logic [OP_W-1:0] OP_CLR   = 3'd1;
  localparam logic [OP_W-1:0] OP_FLIP  = 3'd2;
  localparam logic [OP_W-1:0] OP_PROBE = 3'd3;
  localparam logic [OP_W-1:0] OP_GRAB  = 3'd4;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_READ   = 2'd1,
    S_UPDATE = 2'd2,
    S_DONE   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bitrmw_seq.sv
module bitrmw_seq #(
  parameter int ADDR_W = 32,
  parameter int OP_W   = 3,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [IDX_W-1:0]  cmd_bit,
  output logic              cmd_ready,
  output logic [OP_W-1:0]   op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [IDX_W-1:0]  bit_q,
  output logic              rd_phase,
  output logic              upd_phase,
  output logic              done_phase
);
  import bitrmw_pkg::*;

  seq_state_e state_q, state_d;
  logic       accept;

  assign cmd_ready  = (state_q == S_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign rd_phase   = (state_q == S_READ);
  assign upd_phase  = (state_q == S_UPDATE);
  assign done_phase = (state_q == S_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (accept) state_d = S_READ;
      S_READ:   state_d = S_UPDATE;
      S_UPDATE: state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= cmd_op;
        addr_q <= cmd_addr;
        bit_q  <= cmd_bit;
      end
    end
  end

  // R6: a read only ever follows an accepted command
  p_read_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> $past(cmd_valid && cmd_ready));

  // R6: the update cycle directly follows the read cycle
  p_update_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_phase |-> $past(rd_phase));

  // R6: the result strobe lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_phase |=> !done_phase);

  // R7: the latched command does not move while busy
  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_phase || done_phase) |-> ($stable(addr_q) && $stable(op_q) && $stable(bit_q)));
endmodule

// File: rtl/bitrmw_mask.sv
module bitrmw_mask #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] mask
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_dec
    assign mask[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/bitrmw_alu.sv
module bitrmw_alu #(
  parameter int DATA_W = 8,
  parameter int OP_W   = 3
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] old_byte,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] new_byte,
  output logic [DATA_W-1:0] res_byte,
  output logic              wr_needed
);
  import bitrmw_pkg::*;

  localparam logic [DATA_W-1:0] GRAB_VAL = DATA_W'(1);

  always_comb begin
    new_byte  = old_byte;
    res_byte  = '0;
    wr_needed = 1'b0;
    unique case (op)
      OP_SET: begin
        new_byte  = old_byte | mask;
        res_byte  = old_byte | mask;
        wr_needed = 1'b1;
      end
      OP_CLR: begin
        new_byte  = old_byte & ~mask;
        res_byte  = old_byte & ~mask;
        wr_needed = 1'b1;
      end
      OP_FLIP: begin
        new_byte  = old_byte ^ mask;
        res_byte  = old_byte ^ mask;
        wr_needed = 1'b1;
      end
      OP_PROBE: begin
        res_byte = old_byte & mask;
      end
      OP_GRAB: begin
        new_byte  = GRAB_VAL;
        res_byte  = old_byte;
        wr_needed = 1'b1;
      end
      default: begin
        res_byte = '0;
      end
    endcase
  end
endmodule

// File: rtl/bitrmw_unit.sv
module bitrmw_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int RES_W  = 32,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int OP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [IDX_W-1:0]  cmd_bit,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_lock
);
  import bitrmw_pkg::*;

  localparam int PAD_W = RES_W - DATA_W;

  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  bit_q;
  logic              rd_phase, upd_phase, done_phase;
  logic [DATA_W-1:0] mask, new_byte, res_byte;
  logic              wr_needed;
  logic [RES_W-1:0]  res_q;

  bitrmw_seq #(.ADDR_W(ADDR_W), .OP_W(OP_W), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_bit    (cmd_bit),
    .cmd_ready  (cmd_ready),
    .op_q       (op_q),
    .addr_q     (addr_q),
    .bit_q      (bit_q),
    .rd_phase   (rd_phase),
    .upd_phase  (upd_phase),
    .done_phase (done_phase)
  );

  bitrmw_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .idx  (bit_q),
    .mask (mask)
  );

  bitrmw_alu #(.DATA_W(DATA_W), .OP_W(OP_W)) u_alu (
    .op        (op_q),
    .old_byte  (mem_rdata),
    .mask      (mask),
    .new_byte  (new_byte),
    .res_byte  (res_byte),
    .wr_needed (wr_needed)
  );

  assign mem_addr  = addr_q;
  assign mem_rd_en = rd_phase;
  assign mem_wr_en = upd_phase && wr_needed;
  assign mem_wdata = new_byte;
  assign mem_lock  = (rd_phase || upd_phase) && (op_q == OP_GRAB);
  assign res_valid = done_phase;
  assign res_data  = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (upd_phase) begin
      res_q <= {{PAD_W{1'b0}}, res_byte};
    end
  end

  // R6: a write goes to the address just read, right after the read
  p_write_same_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr)));

  // R6: the result does not change between strobes
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> $stable(res_data));

  // R4: a test operation never writes
  p_probe_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_phase && op_q == OP_PROBE) |-> !mem_wr_en);

  // R5: the locked write stores the constant one
  p_grab_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_lock) |-> (mem_wdata == DATA_W'(1)));

  // R8: a locked read is followed by a locked write
  p_lock_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && mem_rd_en) |=> (mem_lock && mem_wr_en));

  // R8: the lock is only up while the port is in use
  p_lock_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> (mem_rd_en || mem_wr_en));

  // R9: reserved operation codes write nothing
  p_reserved_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_phase && op_q > OP_GRAB) |-> !mem_wr_en);
endmodule

// File: tb/test_bitrmw_unit.sv
`timescale 1ns/1ps
module test_bitrmw_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_addr = '0;
  logic [2:0]  cmd_bit = '0;
  logic        res_valid;
  logic [31:0] res_data;
  logic [31:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rdata;
  logic        mem_wr_en;
  logic [7:0]  mem_wdata;
  logic        mem_lock;

  always #2 clk = ~clk;

  bitrmw_unit i_bitrmw_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bit(cmd_bit),
    .res_valid(res_valid), .res_data(res_data), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_lock(mem_lock)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wr_cnt = 0;
  int lock_cnt = 0;
  int wr_mark = 0;
  int lock_mark = 0;

  function automatic logic [7:0] seed_byte(int i);
    return 8'(i * 37 + 5);
  endfunction

  logic [7:0] mem_model [256];
  logic [7:0] shadow [256];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_model[i] <= seed_byte(i);
      mem_rdata <= '0;
    end else begin
      if (mem_rd_en) mem_rdata <= mem_model[mem_addr[7:0]];
      if (mem_wr_en) mem_model[mem_addr[7:0]] <= mem_wdata;
    end
    cyc <= cyc + 1;
    if (rst_n && mem_wr_en) wr_cnt <= wr_cnt + 1;
    if (rst_n && mem_lock) lock_cnt <= lock_cnt + 1;
  end

  typedef struct {
    logic [31:0] res;
    logic [7:0]  addr_lo;
    logic [7:0]  mem_after;
    int          wrs;
    int          locks;
    int          t0;
    string       req;
  } exp_t;

  exp_t sb[$];

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [31:0] addr, logic [2:0] b, string req);
    exp_t e;
    logic [7:0] old, m, nv;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    old = shadow[addr[7:0]];
    m = 8'(1) << b;
    nv = old;
    e.wrs = 1;
    e.locks = 0;
    case (op)
      3'd0: begin nv = old | m;  e.res = {24'd0, nv}; end
      3'd1: begin nv = old & ~m; e.res = {24'd0, nv}; end
      3'd2: begin nv = old ^ m;  e.res = {24'd0, nv}; end
      3'd3: begin e.res = {24'd0, old & m}; e.wrs = 0; end
      3'd4: begin nv = 8'h01; e.res = {24'd0, old}; e.locks = 2; end
      default: begin e.res = '0; e.wrs = 0; end
    endcase
    shadow[addr[7:0]] = nv;
    e.addr_lo = addr[7:0];
    e.mem_after = nv;
    e.t0 = cyc + 1;
    e.req = req;
    sb.push_back(e);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_addr = addr;
    cmd_bit = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op = 3'd7;
    cmd_addr = 32'hDEAD_BEEF;
    cmd_bit = 3'd5;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7", "unexpected result", res_data, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_data == e.res, e.req, "result", res_data, e.res);
        check(cyc - e.t0 == 2, "R6", "latency", 32'(cyc - e.t0), 32'd2);
        check(wr_cnt - wr_mark == e.wrs, e.req, "write count", 32'(wr_cnt - wr_mark), 32'(e.wrs));
        check(lock_cnt - lock_mark == e.locks, "R8", "lock cycles", 32'(lock_cnt - lock_mark), 32'(e.locks));
        check(mem_model[e.addr_lo] == e.mem_after, e.req, "memory byte", {24'd0, mem_model[e.addr_lo]}, {24'd0, e.mem_after});
        wr_mark = wr_cnt;
        lock_mark = lock_cnt;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = seed_byte(i);
    repeat (3) @(negedge clk);
    // R10: outputs held during reset
    check(cmd_ready == 1'b1, "R10", "ready", 32'(cmd_ready), 32'd1);
    check(res_valid == 1'b0, "R10", "res_valid", 32'(res_valid), 32'd0);
    check({mem_rd_en, mem_wr_en, mem_lock} == 3'b000, "R10", "port strobes",
          32'({mem_rd_en, mem_wr_en, mem_lock}), 32'd0);
    check(res_data == 32'd0, "R10", "res_data", res_data, 32'd0);
    rst_n = 1'b1;

    issue(3'd0, 32'd3, 3'd0, "R1");        // set LSB
    issue(3'd0, 32'd3, 3'd7, "R11");       // set MSB
    issue(3'd1, 32'd4, 3'd2, "R2");
    issue(3'd1, 32'd4, 3'd2, "R2");        // clear already clear
    issue(3'd2, 32'd5, 3'd5, "R3");
    issue(3'd2, 32'd5, 3'd5, "R3");        // toggle back
    issue(3'd3, 32'd6, 3'd1, "R4");
    issue(3'd3, 32'd3, 3'd7, "R4");        // test a set bit
    issue(3'd4, 32'd7, 3'd0, "R5");
    issue(3'd4, 32'd7, 3'd3, "R5");        // old value now 1
    issue(3'd3, 32'd7, 3'd0, "R4");
    issue(3'd5, 32'd8, 3'd0, "R9");
    issue(3'd7, 32'd9, 3'd4, "R9");
    issue(3'd0, 32'hFFFF_FF0A, 3'd7, "R11");
    for (int i = 0; i < 16; i++)
      issue(3'(i % 5), 32'(40 + i), 3'(i % 8), "R1");

    // R7: offer a command while busy
    issue(3'd2, 32'd10, 3'd1, "R3");
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_addr = 32'd20; cmd_bit = 3'd0;
    check(cmd_ready == 1'b0, "R7", "ready while reading", 32'(cmd_ready), 32'd0);
    @(negedge clk);
    check(cmd_ready == 1'b0, "R7", "ready while updating", 32'(cmd_ready), 32'd0);
    @(negedge clk);
    cmd_valid = 1'b0;

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(mem_model[20] == shadow[20], "R7", "poked byte untouched",
          {24'd0, mem_model[20]}, {24'd0, shadow[20]});
    check(sb.size() == 0, "R7", "pending results", 32'(sb.size()), 32'd0);
    check(cmd_ready == 1'b1, "R7", "ready after idle", 32'(cmd_ready), 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule